// File: doc/BRIEF.md
# MDIO Management Command Unit

This block drives the two-wire PHY management bus on behalf of a host that controls it through a few register-style words. The host places a PHY address and a register number in an address word and picks the MDC rate through a config word. For a write it also supplies a write-data word. It then raises a command level and later drops it. On the rising edge of that level the block captures every operand. It then sends a complete management frame on MDC/MDIO and reports busy until the frame ends.

For a read, the block stops driving MDIO from the turnaround onward. It samples the PHY's sixteen reply bits on rising MDC edges. The result appears in a read-data word that keeps its value until the next read completes. MDIO is meant to go through an external open-drain or tristate pad, so the block has separate data-out, output-enable and data-in pins.

Top module: `mdio_mgmt_unit`

## Requirements
- R1: The PHY address is taken from bits 12:8 of `mgmt_addr` and the register number from bits 4:0. Both are sent MSB first in the frame.
- R2: A transaction starts only when `cmd_go` goes from 0 to 1 while the block is idle. Keeping `cmd_go` high after completion starts nothing new. A 0-to-1 change of `cmd_go` while busy is ignored and produces no extra frame.
- R3: Every frame has 64 bit times, sent MSB first: 32 ones, start `01`, an opcode (`01` write, `10` read), 5 PHY-address bits, 5 register bits, a 2-bit turnaround, then 16 data bits. For a write the turnaround is `10` and the data bits are `wr_data`.
- R4: MDC is low while idle. `mdio_o` and `mdio_oe` change only in the clock where MDC falls, or when a frame begins.
- R5: Each MDC half period lasts (D+1) clock cycles, where D is `mgmt_cfg` bits 5:2. A whole frame therefore keeps `busy` high for 128*(D+1) cycles.
- R6: During a read, `mdio_oe` is 0 from the first turnaround bit to the end of the frame. The 16 reply bits are sampled on rising MDC edges, MSB first, and appear on `rd_data` in the clock where `busy` drops.
- R7: `busy` rises in the clock after the start edge is seen. It falls together with the MDC falling edge that ends the last data bit.
- R8: Address, config, write data and operation are captured at the start. Changing them during a frame has no effect on that frame.
- R9: After reset: `mdc`=0, `mdio_oe`=0, `busy`=0, `rd_data`=0.
- R10: A write transaction leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mgmt_addr | input | 16 | Address word: PHY address at 12:8, register number at 4:0 |
| mgmt_cfg | input | 8 | Config word: MDC divider D at 5:2 |
| wr_data | input | 16 | Data sent by a write |
| op_write | input | 1 | 1 selects write, 0 selects read |
| cmd_go | input | 1 | Command level; its rising edge starts a transaction |
| rd_data | output | 16 | Data returned by the latest read |
| busy | output | 1 | High while a frame is in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value when driven |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The hardest case to reach is a second command edge landing in the middle of a frame. The bench lowers and raises `cmd_go` a few clocks into a transaction, then checks that exactly 64 MDC rising edges were seen and that `busy` stays low afterwards. A similar hidden case is an operand change during a frame. To cover it, the bench scrambles the address, config, data and operation inputs partway through a frame and compares the captured frame and its duration with the original request. A PHY model answers reads bit by bit on falling MDC, so a sampling-edge or turnaround error shows up in `rd_data`.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W  = 5;
  localparam int REG_W  = 5;
  localparam int DATA_W = 16;
  localparam int DIV_W  = 4;
  localparam int HALF_W = DIV_W + 1;
  localparam int BODY_W = 32;

  typedef enum logic [1:0] {
    OP_WR = 2'b01,
    OP_RD = 2'b10
  } mdio_op_e;

  typedef struct packed {
    logic              wr;
    logic [PHY_W-1:0]  phy;
    logic [REG_W-1:0]  regn;
    logic [DATA_W-1:0] wdata;
    logic [DIV_W-1:0]  div;
  } mdio_req_t;

  // MDC half period in block clocks for a divider setting
  function automatic logic [HALF_W-1:0] half_cycles(input logic [DIV_W-1:0] div);
    half_cycles = {1'b0, div} + {{(HALF_W-1){1'b0}}, 1'b1};
  endfunction

  // Frame after the preamble: start, opcode, addresses, turnaround, data
  function automatic logic [BODY_W-1:0] frame_body(input mdio_req_t r);
    mdio_op_e op;
    op = r.wr ? OP_WR : OP_RD;
    frame_body = {2'b01, op, r.phy, r.regn, 2'b10,
                  r.wr ? r.wdata : {DATA_W{1'b1}}};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int HALF_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise,
  output logic              fall
);
  localparam logic [HALF_W-1:0] ONE = {{(HALF_W-1){1'b0}}, 1'b1};

  logic [HALF_W-1:0] cnt;
  logic              tick;

  assign tick = run && (cnt == (half - ONE));
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + ONE;
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  mdio_req_t         req,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              last,
  output logic [DATA_W-1:0] rd_word
);
  localparam int FRAME_W = PRE_LEN + BODY_W;
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_LEN + 14);
  localparam logic [IDX_W-1:0] ONE      = {{(IDX_W-1){1'b0}}, 1'b1};

  logic [FRAME_W-1:0] sr;
  logic [IDX_W-1:0]   idx;
  logic               is_rd;
  logic [DATA_W-1:0]  cap;

  assign last    = busy && fall && (idx == LAST_IDX);
  assign mdio_o  = busy && sr[FRAME_W-1];
  assign mdio_oe = busy && !(is_rd && (idx >= TA_IDX));
  assign rd_word = cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      idx   <= '0;
      busy  <= 1'b0;
      is_rd <= 1'b0;
      cap   <= '0;
    end else if (load) begin
      sr    <= {{PRE_LEN{1'b1}}, frame_body(req)};
      idx   <= '0;
      busy  <= 1'b1;
      is_rd <= !req.wr;
      cap   <= '0;
    end else if (busy) begin
      if (rise && is_rd)
        cap <= {cap[DATA_W-2:0], mdio_i};
      if (fall) begin
        sr  <= sr << 1;
        idx <= idx + ONE;
        if (last)
          busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_unit.sv
module mdio_mgmt_unit
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CFG_W   = 8,
  parameter int PHY_LSB = 8,
  parameter int DIV_LSB = 2,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mgmt_addr,
  input  logic [CFG_W-1:0]  mgmt_cfg,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              op_write,
  input  logic              cmd_go,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic              cmd_q;
  logic              start_evt;
  logic              done_evt;
  logic              done_rd;
  logic              mdc_rise;
  logic              mdc_fall;
  logic [DATA_W-1:0] rd_word;
  mdio_req_t         req_next;
  mdio_req_t         req_q;

  always_comb begin
    req_next.wr    = op_write;
    req_next.phy   = mgmt_addr[PHY_LSB +: PHY_W];
    req_next.regn  = mgmt_addr[0 +: REG_W];
    req_next.wdata = wr_data;
    req_next.div   = mgmt_cfg[DIV_LSB +: DIV_W];
  end

  assign start_evt = cmd_go && !cmd_q && !busy;
  assign done_rd   = done_evt && !req_q.wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= 1'b0;
      req_q   <= '0;
      rd_data <= '0;
    end else begin
      cmd_q <= cmd_go;
      if (start_evt)
        req_q <= req_next;
      if (done_rd)
        rd_data <= rd_word;
    end
  end

  mdio_clkdiv #(.HALF_W(HALF_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .half  (half_cycles(req_q.div)),
    .mdc   (mdc),
    .rise  (mdc_rise),
    .fall  (mdc_fall)
  );

  mdio_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_evt),
    .req     (req_next),
    .rise    (mdc_rise),
    .fall    (mdc_fall),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .last    (done_evt),
    .rd_word (rd_word)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_go,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [15:0] rd_data,
  input logic        start_evt,
  input logic        done_rd
);
  p_idle_mdc_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  p_mdio_moves_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_start_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> $rose(cmd_go));

  p_start_sets_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  p_busy_ends_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(mdc));

  p_read_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_rd |-> !mdio_oe);

  p_rdata_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_rd |=> $stable(rd_data));
endmodule

bind mdio_mgmt_unit mdio_mgmt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_go    (cmd_go),
  .busy      (busy),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .rd_data   (rd_data),
  .start_evt (start_evt),
  .done_rd   (done_rd)
);

// File: tb/mdio_mgmt_unit_test.sv
`timescale 1ns/1ps
module mdio_mgmt_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mgmt_addr = '0;
  logic [7:0]  mgmt_cfg = '0;
  logic [15:0] wr_data = '0;
  logic        op_write = 1'b0;
  logic        cmd_go = 1'b0;
  logic [15:0] rd_data;
  logic        busy, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // PHY model state
  int          nb = 0;
  logic [63:0] cap = '0;
  logic [63:0] oecap = '0;
  logic [15:0] phy_val = '0;
  logic [15:0] last_rd = '0;

  always #2.5 clk = ~clk;

  mdio_mgmt_unit uut (
    .clk(clk), .rst_n(rst_n), .mgmt_addr(mgmt_addr), .mgmt_cfg(mgmt_cfg),
    .wr_data(wr_data), .op_write(op_write), .cmd_go(cmd_go), .rd_data(rd_data),
    .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    cap   = {cap[62:0], mdio_oe ? mdio_o : 1'b0};
    oecap = {oecap[62:0], mdio_oe};
    nb    = nb + 1;
  end

  always @(negedge mdc) begin
    if (nb >= 48 && nb < 64) mdio_i = phy_val[63 - nb];
    else                     mdio_i = 1'b1;
  end

  // {wr, phy, reg, div, pad, data}
  localparam logic [31:0] VEC [6] = '{
    {1'b1, 5'd1,  5'd0,  4'd0,  1'b0, 16'h1234},
    {1'b0, 5'd3,  5'd2,  4'd1,  1'b0, 16'hA5C3},
    {1'b1, 5'd31, 5'd31, 4'd3,  1'b0, 16'hFFFF},
    {1'b0, 5'd16, 5'd1,  4'd0,  1'b0, 16'h0001},
    {1'b1, 5'd0,  5'd17, 4'd13, 1'b0, 16'h8000},
    {1'b0, 5'd21, 5'd10, 4'd2,  1'b0, 16'h7E81}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // mode: 0 normal, 1 hold cmd high, 2 re-edge while busy, 3 scramble inputs mid-frame
  task automatic run_xfer(input logic wr, input logic [4:0] phy, input logic [4:0] regn,
                          input logic [3:0] div, input logic [15:0] data, input int mode,
                          output int cycles);
    @(negedge clk);
    mgmt_addr = {3'b000, phy, 3'b000, regn};
    mgmt_cfg  = {2'b00, div, 2'b00};
    wr_data   = wr ? data : 16'h0000;
    op_write  = wr;
    phy_val   = data;
    nb = 0; cap = '0; oecap = '0;
    cmd_go = 1'b1;
    cycles = 0;
    @(negedge clk);
    while (busy && cycles < 5000) begin
      cycles++;
      if (cycles == 3 && mode != 1) cmd_go = 1'b0;
      if (mode == 2 && cycles == 10) cmd_go = 1'b1;
      if (mode == 2 && cycles == 14) cmd_go = 1'b0;
      if (mode == 3 && cycles == 20) begin
        mgmt_addr = 16'hFFFF; mgmt_cfg = 8'h00; wr_data = 16'h0F0F; op_write = ~wr;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_xfer(input logic wr, input logic [4:0] phy, input logic [4:0] regn,
                            input logic [3:0] div, input logic [15:0] data, input int cycles);
    logic [63:0] exp_f, exp_oe;
    exp_f  = {32'hFFFF_FFFF, 2'b01, wr ? 2'b01 : 2'b10, phy, regn,
              wr ? 2'b10 : 2'b00, wr ? data : 16'h0000};
    exp_oe = wr ? 64'hFFFF_FFFF_FFFF_FFFF : ~64'h3FFFF;
    chk(cap == exp_f, "R1/R3 frame bits", cap, exp_f);
    chk(oecap == exp_oe, "R6 output enable per bit", oecap, exp_oe);
    chk(cycles == 128 * (div + 1), "R5/R7 busy duration", 64'(cycles), 64'(128 * (div + 1)));
    if (!wr) last_rd = data;
    chk(rd_data == last_rd, wr ? "R10 rd_data after write" : "R6 rd_data after read",
        64'(rd_data), 64'(last_rd));
  endtask

  initial begin
    #900000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(mdc == 1'b0, "R9 mdc at reset", 64'(mdc), 64'd0);
    chk(mdio_oe == 1'b0, "R9 oe at reset", 64'(mdio_oe), 64'd0);
    chk(busy == 1'b0, "R9 busy at reset", 64'(busy), 64'd0);
    chk(rd_data == 16'h0, "R9 rd_data at reset", 64'(rd_data), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      logic [31:0] v;
      v = VEC[i];
      run_xfer(v[31], v[30:26], v[25:21], v[20:17], v[15:0], 0, cyc);
      check_xfer(v[31], v[30:26], v[25:21], v[20:17], v[15:0], cyc);
      repeat (4) @(negedge clk);
    end

    // R7 busy visible right after start edge
    @(negedge clk);
    mgmt_addr = {3'b000, 5'd2, 3'b000, 5'd3}; mgmt_cfg = 8'h00; op_write = 1'b1;
    nb = 0; cmd_go = 1'b1;
    chk(busy == 1'b0, "R7 busy before edge", 64'(busy), 64'd0);
    @(negedge clk);
    chk(busy == 1'b1, "R7 busy after edge", 64'(busy), 64'd1);
    chk(mdc == 1'b0, "R4 mdc low at frame start", 64'(mdc), 64'd0);
    cmd_go = 1'b0;
    while (busy) @(negedge clk);

    // R2 command level held high: one frame only
    run_xfer(1'b1, 5'd5, 5'd6, 4'd0, 16'hBEEF, 1, cyc);
    check_xfer(1'b1, 5'd5, 5'd6, 4'd0, 16'hBEEF, cyc);
    repeat (40) @(negedge clk);
    chk(busy == 1'b0, "R2 held command restarts nothing", 64'(busy), 64'd0);
    chk(nb == 64, "R2 MDC rises with held command", 64'(nb), 64'd64);
    cmd_go = 1'b0;
    repeat (3) @(negedge clk);

    // R2 new edge during busy is ignored
    run_xfer(1'b0, 5'd9, 5'd4, 4'd1, 16'h5A5A, 2, cyc);
    check_xfer(1'b0, 5'd9, 5'd4, 4'd1, 16'h5A5A, cyc);
    repeat (40) @(negedge clk);
    chk(busy == 1'b0, "R2 edge while busy ignored", 64'(busy), 64'd0);
    chk(nb == 64, "R2 MDC rises after busy edge", 64'(nb), 64'd64);

    // R8 inputs changed mid-frame
    run_xfer(1'b1, 5'd12, 5'd7, 4'd2, 16'hC001, 3, cyc);
    check_xfer(1'b1, 5'd12, 5'd7, 4'd2, 16'hC001, cyc);
    chk(cyc == 384, "R8 divider latched at start", 64'(cyc), 64'd384);
    cmd_go = 1'b0;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule